// File: doc/BRIEF.md
# PCI Configuration Header Shadow Bank

This block keeps a local copy of a type-0 PCI configuration header in flops and serves it over a plain word-addressed register bus. Software or a configuration agent writes words with per-byte lane enables and reads any word combinationally in the same cycle. The block has three ways of guarding writes. Some words need an unlock key first, and they lock again by themselves. The class code can be written once only. The command, timing and base address words are writable only while a management-enable bit in the setup word is set.

The two base address words are also driven straight out to the address decoders. A `bars_stable` flag goes low when either base word is written. It stays low through a fixed settling window, so the decoders use a new base only after it has settled. The bus has no handshake. A write completes on the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` with no wait state. The block never applies back-pressure.

Word map (word address on `bus_addr`): 0 key word, 1 setup, 2 subsystem IDs, 3 device/vendor identity, 4 command/status, 5 class code/revision, 6 latency/cache line, 7 DRAM base, 8 MMIO base, 9 max-latency/min-grant. Any other word reads zero.

Top module: `cfg_shadow_top`

## Requirements
- R1: After reset the words read as follows: command 0x0000 with status 0x0290 in bits 31:16; class code 0x048000 with revision 0x01 in bits 7:0; MMIO base 0x1BE00000; DRAM base, setup, subsystem, latency/cache and max-latency/min-grant all zero. Both key groups are locked and `bars_stable` is 1.
- R2: The key word (word 0) always reads zero. A key is recognised only when its byte equals 0xCA and that byte lane is enabled. Any other value leaves both locks as they were.
- R3: Writing 0xCA to bits 15:8 of word 0 opens the subsystem word (word 2). The next write to word 2 updates it and relocks it. Writes to word 2 while it is locked are ignored.
- R4: Writing 0xCA to bits 7:0 of word 0 opens the setup group: setup (word 1), class code (word 5) and max-latency/min-grant (word 9). Any write to word 1 while the group is open updates it and relocks the whole group. Writes to the group while it is locked are ignored.
- R5: The class code (bits 31:8 of word 5) takes only its first write accepted while the group is open. After that it stays read-only until reset. The revision byte never changes.
- R6: Command (word 4, bits 15:0), latency/cache (word 6, bits 15:0) and both base words accept writes only while setup bit 1 is 1. Otherwise writes to them are ignored.
- R7: In the DRAM base word only bits 31:21 are writable. Bits 20:4 and 2:0 read zero, and bit 3 reads setup bit 0. `dram_base` shows the same value.
- R8: In the MMIO base word bits 31:4 are writable and bits 3:0 read zero. `mmio_base` shows the same value.
- R9: A write strobe to word 7 or word 8 drives `bars_stable` low for exactly 10 cycles after that edge. A new base write inside the window restarts the count.
- R10: Each enabled byte lane of `bus_be` (bit n covers data bits 8n+7:8n) updates only its own byte of a writable field.
- R11: The identity word (word 3) reads the device ID in bits 31:16 and the vendor ID in bits 15:0, and ignores writes. Unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dram_base | output | 32 | Current DRAM base word |
| mmio_base | output | 32 | Current MMIO base word |
| bars_stable | output | 1 | High when base values have settled |

## Verification
Two things can land on one clock edge. A write to the setup word updates the management-enable and prefetch bits and relocks its group in the same cycle. A base-word write can arrive while a settling window is still counting. The bench checks the first by writing the setup word once and then probing both results. A further group write must be ignored. The base words must accept or refuse writes under the new enable bit, and the DRAM prefetch bit must change. For the second, the bench writes the MMIO base a second time in the middle of a window. It then samples `bars_stable` on every following cycle and expects the full window again from the second write.

// File: rtl/cfg_shadow_pkg.sv
`timescale 1ns/1ps
package cfg_shadow_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    W_KEYS     = 4'd0,
    W_SETUP    = 4'd1,
    W_SUBSYS   = 4'd2,
    W_IDENT    = 4'd3,
    W_CMDSTAT  = 4'd4,
    W_CLASS    = 4'd5,
    W_LATCACHE = 4'd6,
    W_BAR_DRAM = 4'd7,
    W_BAR_MMIO = 4'd8,
    W_GRANT    = 4'd9
  } cfg_word_e;

  localparam logic [7:0]  UNLOCK_KEY   = 8'hCA;
  localparam logic [15:0] STATUS_IMAGE = 16'h0290;
  localparam logic [23:0] CLASS_RESET  = 24'h048000;
  localparam logic [31:0] MMIO_RESET   = 32'h1BE00000;
  localparam logic [31:0] DRAM_WMASK   = 32'hFFE00000;
  localparam logic [31:0] MMIO_WMASK   = 32'hFFFFFFF0;
endpackage

// File: rtl/cfg_field_reg.sv
`timescale 1ns/1ps
// Byte-lane masked register with a fixed writable-bit mask.
module cfg_field_reg #(
  parameter int           W     = 32,
  parameter logic [W-1:0] RST   = '0,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [W/8-1:0] lane_en,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   q
);
  localparam int LANES = W / 8;

  logic [W-1:0] lane_bits;
  logic [W-1:0] upd_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[g*8 +: 8] = {8{lane_en[g]}};
  end

  assign upd_mask = WMASK & lane_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= (q & ~upd_mask) | (wdata & upd_mask);
  end

  // R6: a register only moves on an enabled write
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  // R10: disabled lanes and fixed bits never change
  assert_lane_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~$past(upd_mask)) == ($past(q) & ~$past(upd_mask))));
endmodule

// File: rtl/cfg_key_lock.sv
`timescale 1ns/1ps
// Two key-opened write groups with automatic relock.
module cfg_key_lock
  import cfg_shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [1:0]  key_be,
  input  logic [15:0] key_data,
  input  logic        ss_wr,
  input  logic        grp_wr,
  output logic        ss_open,
  output logic        grp_open
);
  logic ss_hit, grp_hit;

  assign ss_hit  = key_wr && key_be[1] && (key_data[15:8] == UNLOCK_KEY);
  assign grp_hit = key_wr && key_be[0] && (key_data[7:0]  == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_open  <= 1'b0;
      grp_open <= 1'b0;
    end else begin
      if (ss_hit)                  ss_open <= 1'b1;
      else if (ss_wr && ss_open)   ss_open <= 1'b0;
      if (grp_hit)                 grp_open <= 1'b1;
      else if (grp_wr && grp_open) grp_open <= 1'b0;
    end
  end

  assert_ss_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_open && ss_wr && !key_wr) |=> !ss_open);
  assert_grp_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_open && grp_wr && !key_wr) |=> !grp_open);
  assert_ss_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_open) |-> $past(key_wr && key_be[1] && key_data[15:8] == UNLOCK_KEY));
  assert_grp_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_open) |-> $past(key_wr && key_be[0] && key_data[7:0] == UNLOCK_KEY));
endmodule

// File: rtl/cfg_settle_timer.sv
`timescale 1ns/1ps
// Holds the stable flag low for SETTLE cycles after every restart.
module cfg_settle_timer #(
  parameter int SETTLE = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic stable
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= CNT_W'(SETTLE);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign stable = (cnt == '0);

  assert_restart_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !stable);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SETTLE));
  assert_stays_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stable && !restart) |=> stable);
endmodule

// File: rtl/cfg_shadow_top.sv
`timescale 1ns/1ps
module cfg_shadow_top
  import cfg_shadow_pkg::*;
#(
  parameter logic [15:0] DEVICE_ID     = 16'h7A21,
  parameter logic [15:0] VENDOR_ID     = 16'h1E5D,
  parameter logic [7:0]  REVISION      = 8'h01,
  parameter int          SETTLE_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       dram_base,
  output logic [31:0]       mmio_base,
  output logic              bars_stable
);
  logic wr_keys, wr_setup, wr_subsys, wr_cmd, wr_class, wr_lat;
  logic wr_dram, wr_mmio, wr_grant;
  logic ss_open, grp_open, mgmt_en, class_done, class_take;

  logic [7:0]  setup_q;
  logic [31:0] subsys_q;
  logic [15:0] cmd_q;
  logic [23:0] class_q;
  logic [15:0] lat_q;
  logic [31:0] dram_q;
  logic [31:0] mmio_q;
  logic [15:0] grant_q;

  assign wr_keys   = bus_wr && (bus_addr == W_KEYS);
  assign wr_setup  = bus_wr && (bus_addr == W_SETUP);
  assign wr_subsys = bus_wr && (bus_addr == W_SUBSYS);
  assign wr_cmd    = bus_wr && (bus_addr == W_CMDSTAT);
  assign wr_class  = bus_wr && (bus_addr == W_CLASS);
  assign wr_lat    = bus_wr && (bus_addr == W_LATCACHE);
  assign wr_dram   = bus_wr && (bus_addr == W_BAR_DRAM);
  assign wr_mmio   = bus_wr && (bus_addr == W_BAR_MMIO);
  assign wr_grant  = bus_wr && (bus_addr == W_GRANT);

  assign mgmt_en = setup_q[1];

  cfg_key_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (wr_keys),
    .key_be   (bus_be[1:0]),
    .key_data (bus_wdata[15:0]),
    .ss_wr    (wr_subsys),
    .grp_wr   (wr_setup),
    .ss_open  (ss_open),
    .grp_open (grp_open)
  );

  cfg_field_reg #(.W(8)) u_setup (
    .clk(clk), .rst_n(rst_n), .we(wr_setup && grp_open),
    .lane_en(bus_be[0]), .wdata(bus_wdata[7:0]), .q(setup_q));

  cfg_field_reg #(.W(32)) u_subsys (
    .clk(clk), .rst_n(rst_n), .we(wr_subsys && ss_open),
    .lane_en(bus_be), .wdata(bus_wdata), .q(subsys_q));

  cfg_field_reg #(.W(16)) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(wr_cmd && mgmt_en),
    .lane_en(bus_be[1:0]), .wdata(bus_wdata[15:0]), .q(cmd_q));

  // Class code: one accepted write while the group is open
  assign class_take = wr_class && grp_open && !class_done && (bus_be[3:1] != 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          class_done <= 1'b0;
    else if (class_take) class_done <= 1'b1;
  end

  cfg_field_reg #(.W(24), .RST(CLASS_RESET)) u_class (
    .clk(clk), .rst_n(rst_n), .we(class_take),
    .lane_en(bus_be[3:1]), .wdata(bus_wdata[31:8]), .q(class_q));

  cfg_field_reg #(.W(16)) u_lat (
    .clk(clk), .rst_n(rst_n), .we(wr_lat && mgmt_en),
    .lane_en(bus_be[1:0]), .wdata(bus_wdata[15:0]), .q(lat_q));

  cfg_field_reg #(.W(32), .WMASK(DRAM_WMASK)) u_dram (
    .clk(clk), .rst_n(rst_n), .we(wr_dram && mgmt_en),
    .lane_en(bus_be), .wdata(bus_wdata), .q(dram_q));

  cfg_field_reg #(.W(32), .RST(MMIO_RESET), .WMASK(MMIO_WMASK)) u_mmio (
    .clk(clk), .rst_n(rst_n), .we(wr_mmio && mgmt_en),
    .lane_en(bus_be), .wdata(bus_wdata), .q(mmio_q));

  cfg_field_reg #(.W(16)) u_grant (
    .clk(clk), .rst_n(rst_n), .we(wr_grant && grp_open),
    .lane_en(bus_be[1:0]), .wdata(bus_wdata[15:0]), .q(grant_q));

  cfg_settle_timer #(.SETTLE(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_dram || wr_mmio),
    .stable  (bars_stable)
  );

  assign dram_base = {dram_q[31:4], setup_q[0], 3'b000};
  assign mmio_base = mmio_q;

  always_comb begin
    case (bus_addr)
      W_SETUP:    bus_rdata = {24'h0, setup_q};
      W_SUBSYS:   bus_rdata = subsys_q;
      W_IDENT:    bus_rdata = {DEVICE_ID, VENDOR_ID};
      W_CMDSTAT:  bus_rdata = {STATUS_IMAGE, cmd_q};
      W_CLASS:    bus_rdata = {class_q, REVISION};
      W_LATCACHE: bus_rdata = {16'h0, lat_q};
      W_BAR_DRAM: bus_rdata = dram_base;
      W_BAR_MMIO: bus_rdata = mmio_base;
      W_GRANT:    bus_rdata = {16'h0, grant_q};
      default:    bus_rdata = 32'h0;
    endcase
  end

  assert_class_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    class_done |=> $stable(class_q));
  assert_cmd_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_en |=> $stable(cmd_q));
  assert_bars_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_en |=> ($stable(dram_q) && $stable(mmio_q)));
  assert_subsys_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_open |=> $stable(subsys_q));
  assert_dram_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_base[20:4] == '0) && (dram_base[2:0] == '0));
endmodule

// File: tb/test_cfg_shadow_top.sv
`timescale 1ns/1ps
module test_cfg_shadow_top;
  localparam logic [31:0] IDENT = {16'h7A21, 16'h1E5D};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, dram_base, mmio_base;
  logic        bars_stable;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  int          kind_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cfg_shadow_top i_cfg_shadow_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dram_base(dram_base), .mmio_base(mmio_base), .bars_stable(bars_stable));

  // Monitor: compare after each edge, away from the edge itself
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      logic [31:0] e, a;
      int k;
      string t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      case (k)
        1:       a = {31'h0, bars_stable};
        2:       a = dram_base;
        3:       a = mmio_base;
        default: a = bus_rdata;
      endcase
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_be = be; bus_wdata = d;
  endtask

  task automatic push(input int k, input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
    exp_q.push_back(e); kind_q.push_back(k); tag_q.push_back(t);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    push(0, a, e, t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 1'b0;
    end
  endtask

  // Called right after a base write: 9 low samples then high
  task automatic window(input string t);
    for (int i = 0; i < 9; i++) push(1, 4'd0, 32'h0, t);
    push(1, 4'd0, 32'h1, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    push(1, 4'd0, 32'h1, "R1 stable after reset");
    rd(4'd0, 32'h0, "R2 key word reads zero");
    rd(4'd1, 32'h0, "R1 setup reset");
    rd(4'd2, 32'h0, "R1 subsys reset");
    rd(4'd3, IDENT, "R11 identity");
    rd(4'd4, 32'h0290_0000, "R1 command/status reset");
    rd(4'd5, 32'h0480_0001, "R1 class/revision reset");
    rd(4'd6, 32'h0, "R1 latency/cache reset");
    rd(4'd7, 32'h0, "R1 dram base reset");
    rd(4'd8, 32'h1BE0_0000, "R1 mmio base reset");
    rd(4'd9, 32'h0, "R1 grant reset");
    rd(4'd15, 32'h0, "R11 unmapped word");
    // Locked writes are ignored
    wr(4'd2, 4'hF, 32'h1234_5678); rd(4'd2, 32'h0, "R3 locked subsys write");
    wr(4'd1, 4'hF, 32'hFF);        rd(4'd1, 32'h0, "R4 locked setup write");
    wr(4'd5, 4'hF, 32'hAABB_CC77); rd(4'd5, 32'h0480_0001, "R5 locked class write");
    wr(4'd4, 4'hF, 32'hFFFF_FFFF); rd(4'd4, 32'h0290_0000, "R6 command with mgmt off");
    wr(4'd8, 4'hF, 32'hFFFF_FFFF); rd(4'd8, 32'h1BE0_0000, "R6 mmio with mgmt off");
    // Wrong key and disabled key lanes
    wr(4'd0, 4'hF, 32'h0000_CBCB);
    wr(4'd1, 4'h1, 32'h03); rd(4'd1, 32'h0, "R2 wrong key");
    wr(4'd0, 4'hC, 32'h0000_CACA);
    wr(4'd1, 4'h1, 32'h03); rd(4'd1, 32'h0, "R2 key lane disabled");
    wr(4'd2, 4'hF, 32'h1); rd(4'd2, 32'h0, "R2 subsys still locked");
    // Group key
    wr(4'd0, 4'h1, 32'h0000_00CA); rd(4'd0, 32'h0, "R2 key readback zero");
    wr(4'd9, 4'h3, 32'h0000_3C0A); rd(4'd9, 32'h3C0A, "R4 grant open write");
    wr(4'd5, 4'hE, 32'hAABB_CC77); rd(4'd5, 32'hAABB_CC01, "R5 first class write");
    wr(4'd5, 4'hF, 32'h1122_3344); rd(4'd5, 32'hAABB_CC01, "R5 second class write");
    wr(4'd1, 4'h1, 32'h03);        rd(4'd1, 32'h03, "R4 setup write");
    wr(4'd9, 4'h3, 32'h0000_1111); rd(4'd9, 32'h3C0A, "R4 relocked after setup");
    // Management enabled
    wr(4'd4, 4'h3, 32'hFFFF_0147); rd(4'd4, 32'h0290_0147, "R6 command with mgmt on");
    wr(4'd6, 4'h2, 32'h0000_ABCD); rd(4'd6, 32'h0000_AB00, "R10 byte lane gate");
    wr(4'd7, 4'hF, 32'hFFFF_FFFF); rd(4'd7, 32'hFFE0_0008, "R7 dram writable bits");
    push(2, 4'd0, 32'hFFE0_0008, "R7 dram_base port");
    wr(4'd8, 4'hF, 32'h1234_567F); rd(4'd8, 32'h1234_5670, "R8 mmio writable bits");
    push(3, 4'd0, 32'h1234_5670, "R8 mmio_base port");
    // Settle window
    idle(12);
    push(1, 4'd0, 32'h1, "R9 settled before write");
    wr(4'd7, 4'hF, 32'h0020_0000);
    window("R9 single write window");
    wr(4'd8, 4'hF, 32'h0000_1000);
    for (int i = 0; i < 4; i++) push(1, 4'd0, 32'h0, "R9 first window");
    wr(4'd8, 4'hF, 32'h0000_2000);
    window("R9 restarted window");
    // Subsystem key
    wr(4'd0, 4'h2, 32'h0000_CA00);
    wr(4'd2, 4'hF, 32'hBEEF_1234); rd(4'd2, 32'hBEEF_1234, "R3 subsys open write");
    wr(4'd2, 4'hF, 32'h0);         rd(4'd2, 32'hBEEF_1234, "R3 subsys relocked");
    // Prefetch follows setup bit 0
    wr(4'd0, 4'h1, 32'hCA);
    wr(4'd1, 4'h1, 32'h02); rd(4'd7, 32'h0020_0000, "R7 prefetch cleared");
    // Management off again
    wr(4'd0, 4'h1, 32'hCA);
    wr(4'd1, 4'h1, 32'h00);
    wr(4'd4, 4'hF, 32'h0000_FFFF); rd(4'd4, 32'h0290_0147, "R6 command after mgmt off");
    wr(4'd3, 4'hF, 32'hFFFF_FFFF); rd(4'd3, IDENT, "R11 identity write ignored");
    idle(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule